// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the reset for the logic around it. It keeps an internal active-high reset and an active-low reset output for external devices asserted until three conditions are all true: the supply is good, the oscillator is running, and the external active-low reset input is high. Once all three hold, it counts a fixed number of millisecond ticks before it releases both resets together. The default is five ticks, which is about 5 ms.

If any of the three conditions drops, both resets assert at once, without waiting for a clock edge, and the count starts again from zero. A bus-reset indication is accepted as an input but does not affect either reset.

The three qualifying inputs are plain digital levels. They are combined and passed through a short synchronizer so that release happens cleanly on a clock edge. There is no data stream, so every pin is a plain control pin with no valid/ready handshake.

Top module: `por_sequencer`

## Requirements
- R1: While `supply_ok` is 0, `core_rst` is 1 and `rst_out_n` is 0.
- R2: While `osc_run` is 0, `core_rst` is 1 and `rst_out_n` is 0.
- R3: While `ext_rst_n` is 0, `core_rst` is 1 and `rst_out_n` is 0.
- R4: After all three conditions go high, release waits for the synchronizer. Both resets then stay asserted until `DELAY_TICKS` qualified `ms_tick` pulses have been sampled. They deassert on the clock edge that follows the edge sampling the last of those pulses.
- R5: Driving `ext_rst_n` low asserts both resets immediately, with no clock edge needed. The same holds for a drop of `supply_ok` or `osc_run`.
- R6: `bus_reset` has no effect on either reset output, at any time.
- R7: If any condition drops during the delay, the tick count restarts from zero after the conditions return.
- R8: `core_rst` is always the complement of `rst_out_n`, so both change on the same edge.
- R9: The combined release condition passes through `SYNC_STAGES` (default 2) flops. Ticks sampled on the first `SYNC_STAGES` edges after release are not counted.
- R10: Once released, both resets stay released while all three conditions remain high, however many more ticks arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| supply_ok | input | 1 | Supply above threshold (1 = good) |
| osc_run | input | 1 | Oscillator running (1 = running) |
| ext_rst_n | input | 1 | External active-low reset request |
| bus_reset | input | 1 | Bus reset indication (ignored) |
| core_rst | output | 1 | Internal active-high reset |
| rst_out_n | output | 1 | Active-low reset output to external logic |

## Verification
Each release condition is held low on its own while ticks keep arriving, which shows that every one of the three inputs is required. A clean release is counted tick by tick, so a count that finishes one tick early or late is caught. Ticks that arrive during the synchronizer window separate a design that counts them from one that ignores them. A drop in the middle of the delay, a mid-cycle external reset, and toggling of the bus reset separate restart, asynchronous assertion and true independence from the bus reset.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned DEFAULT_DELAY_TICKS = 5;
  localparam int unsigned DEFAULT_SYNC_STAGES = 2;
endpackage

// File: rtl/por_qual_sync.sv
module por_qual_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  output logic qual_s
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge clr) begin
        if (clr) stg <= '0;
        else     stg <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge clr) begin
        if (clr) stg <= '0;
        else     stg <= {stg[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign qual_s = stg[STAGES-1];
endmodule

// File: rtl/por_delay_cnt.sv
module por_delay_cnt #(
  parameter int unsigned DELAY_TICKS = 5
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (run && tick && !done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/por_out_stage.sv
module por_out_stage (
  input  logic clk,
  input  logic clr,
  input  logic release_ok,
  output logic core_rst,
  output logic rst_out_n
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      core_rst  <= 1'b1;
      rst_out_n <= 1'b0;
    end else begin
      core_rst  <= !release_ok;
      rst_out_n <= release_ok;
    end
  end
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = DEFAULT_DELAY_TICKS,
  parameter int unsigned SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
  input  logic clk,
  input  logic ms_tick,
  input  logic supply_ok,
  input  logic osc_run,
  input  logic ext_rst_n,
  input  logic bus_reset,
  output logic core_rst,
  output logic rst_out_n
);
  logic hold;
  logic qual_s;
  logic done;
  logic unused_bus_rst;

  // bus reset is deliberately not part of the release condition
  assign unused_bus_rst = bus_reset;
  assign hold = !(supply_ok && osc_run && ext_rst_n);

  por_qual_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr(hold), .qual_s(qual_s)
  );

  por_delay_cnt #(.DELAY_TICKS(DELAY_TICKS)) u_cnt (
    .clk(clk), .clr(hold), .run(qual_s), .tick(ms_tick), .done(done)
  );

  por_out_stage u_out (
    .clk(clk), .clr(hold), .release_ok(done),
    .core_rst(core_rst), .rst_out_n(rst_out_n)
  );
endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk (
  input logic clk,
  input logic supply_ok,
  input logic osc_run,
  input logic ext_rst_n,
  input logic core_rst,
  input logic rst_out_n
);
  p_supply_hold_r1: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !supply_ok |-> (!rst_out_n && core_rst));

  p_osc_hold_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !osc_run |-> (!rst_out_n && core_rst));

  p_ext_hold_r3: assert property (@(posedge clk) disable iff (!supply_ok)
    !ext_rst_n |-> (!rst_out_n && core_rst));

  p_release_qual_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(rst_out_n) |-> $past(supply_ok && osc_run));

  p_complement_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    core_rst == !rst_out_n);

  p_stay_released_r10: assert property (@(posedge clk)
    disable iff (!(supply_ok && osc_run && ext_rst_n))
    rst_out_n |=> rst_out_n);
endmodule

bind por_sequencer por_sequencer_chk u_chk (
  .clk(clk), .supply_ok(supply_ok), .osc_run(osc_run),
  .ext_rst_n(ext_rst_n), .core_rst(core_rst), .rst_out_n(rst_out_n)
);

// File: tb/tb_por_sequencer.sv
module tb_por_sequencer;
  localparam int unsigned DLY = 4;

  logic clk = 1'b0;
  logic ms_tick = 1'b0, supply_ok = 1'b0, osc_run = 1'b0;
  logic ext_rst_n = 1'b0, bus_reset = 1'b0;
  logic core_rst, rst_out_n;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  por_sequencer #(.DELAY_TICKS(DLY), .SYNC_STAGES(2)) dut (
    .clk(clk), .ms_tick(ms_tick), .supply_ok(supply_ok), .osc_run(osc_run),
    .ext_rst_n(ext_rst_n), .bus_reset(bus_reset),
    .core_rst(core_rst), .rst_out_n(rst_out_n)
  );

  task automatic chk(input string req, input logic exp_n);
    total++;
    if (rst_out_n !== exp_n || core_rst !== !exp_n) begin
      bad++;
      $display("FAIL %s: rst_out_n=%b core_rst=%b expected rst_out_n=%b core_rst=%b",
               req, rst_out_n, core_rst, exp_n, !exp_n);
    end
  endtask

  task automatic all_low();
    @(negedge clk);
    supply_ok = 0; osc_run = 0; ext_rst_n = 0; ms_tick = 0;
    @(negedge clk);
  endtask

  task automatic go_live();
    @(negedge clk);
    supply_ok = 1; osc_run = 1; ext_rst_n = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1 reset state", 1'b0);
  endtask

  task automatic t_single_low(input int which);
    all_low();
    @(negedge clk);
    supply_ok = (which != 0); osc_run = (which != 1); ext_rst_n = (which != 2);
    repeat (DLY + 3) tick_once();
    case (which)
      0: chk("R1 supply low holds", 1'b0);
      1: chk("R2 osc low holds", 1'b0);
      default: chk("R3 ext low holds", 1'b0);
    endcase
  endtask

  task automatic t_release();
    all_low();
    go_live();
    for (int i = 0; i < DLY - 1; i++) tick_once();
    chk("R4 held before last tick", 1'b0);
    tick_once();
    chk("R4 held on last tick edge", 1'b0);
    @(negedge clk);
    chk("R4 released next edge", 1'b1);
    chk("R8 complement after release", 1'b1);
    repeat (DLY + 2) tick_once();
    chk("R10 stays released", 1'b1);
  endtask

  task automatic t_async_ext();
    @(negedge clk);
    #1 ext_rst_n = 0;
    #1 chk("R5 immediate on ext low", 1'b0);
    @(negedge clk);
    ext_rst_n = 1;
    #1 osc_run = 0;
    #1 chk("R5 immediate on osc low", 1'b0);
    osc_run = 1;
  endtask

  task automatic t_bus_reset();
    all_low();
    go_live();
    for (int i = 0; i < DLY - 1; i++) begin
      @(negedge clk) begin ms_tick = 1; bus_reset = 1; end
      @(negedge clk) begin ms_tick = 0; bus_reset = 0; end
    end
    chk("R6 bus reset no early release", 1'b0);
    @(negedge clk) bus_reset = 1;
    tick_once();
    @(negedge clk);
    chk("R6 bus reset no delay", 1'b1);
    repeat (3) @(negedge clk) bus_reset = ~bus_reset;
    chk("R6 bus reset ignored after release", 1'b1);
    @(negedge clk) bus_reset = 0;
  endtask

  task automatic t_restart();
    all_low();
    go_live();
    for (int i = 0; i < DLY - 1; i++) tick_once();
    @(negedge clk) supply_ok = 0;
    @(negedge clk) supply_ok = 1;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < DLY - 1; i++) tick_once();
    @(negedge clk);
    chk("R7 count restarted", 1'b0);
    tick_once();
    @(negedge clk);
    chk("R7 release after full count", 1'b1);
  endtask

  task automatic t_sync_window();
    all_low();
    @(negedge clk);
    supply_ok = 1; osc_run = 1; ext_rst_n = 1; ms_tick = 1;
    @(negedge clk);
    @(negedge clk) ms_tick = 0;
    for (int i = 0; i < DLY - 1; i++) tick_once();
    @(negedge clk);
    chk("R9 early ticks not counted", 1'b0);
    tick_once();
    @(negedge clk);
    chk("R9 release after qualified ticks", 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_single_low(0);
    t_single_low(1);
    t_single_low(2);
    t_release();
    t_async_ext();
    t_bus_reset();
    t_restart();
    t_sync_window();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule